// File: doc/BRIEF.md
# Reprogrammable FIR Filter with Staged Coefficient Swap

This block is a direct-form FIR filter. Its tap count is fixed and all of its multipliers run in parallel, so it accepts one new sample on every clock. Its coefficients are not fixed at build time. A host loads them one at a time through a small port that carries a value, an address, a write enable and a commit strobe.

Host writes land in a staging bank. The multiply-accumulate datapath never reads that bank. It reads only an active bank, and the whole staging bank is copied into the active bank in a single edge when the commit strobe is sampled high. A complete new response can therefore be staged while samples keep streaming through the old one, and the switch happens at one well-defined sample.

Both banks, the delay line and the output pipeline start cleared, so the filter produces zeros until it is programmed and committed.

Top module: `fir_prog_top`

## Requirements
- R1: A synchronous reset clears the delay line, the staging bank, the active bank and the pipeline. Directly after reset `outValid` is 0 and `outData` is 0, and a sample sent before any commit produces an output of 0.
- R2: On a clock edge where `coefWe` is 1 and `coefAddr` is below TAPS, `coefData` is stored into staging entry `coefAddr`. Entry k multiplies the sample that is k accepted samples old, with entry 0 multiplying the newest.
- R3: A write whose `coefAddr` is TAPS or above, which with the default 4-bit address means 8 to 15, changes no staging entry.
- R4: On a clock edge where `coefDone` is 1, every active entry takes the value its staging entry held before that edge. A write on the same edge goes to the staging bank only and is not part of that copy.
- R5: Staging writes without a commit do not change any output.
- R6: `outData` is the full-precision signed sum, over all taps k, of active[k] times the sample k places back. It is 35 bits wide at the defaults, so eight products of -32768 by -32768 give exactly 2^33.
- R7: The delay line shifts only on edges where `inValid` is 1. Idle cycles leave the sample history unchanged.
- R8: A sample accepted on the same edge as a commit, or on a later edge, is filtered with the new set. Outputs for samples accepted on earlier edges use the old set.
- R9: With `inValid` held at 1 the filter accepts a sample on every edge. `outValid` and `outData` for the sample accepted on edge e change on edge e+1, so `outValid` equals `inValid` delayed two clock samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coefData | input | 16 | Coefficient value, signed |
| coefAddr | input | 4 | Staging entry index |
| coefWe | input | 1 | Write enable for the staging bank |
| coefDone | input | 1 | Commit strobe, copies staging to active |
| inValid | input | 1 | Input sample valid |
| inData | input | 16 | Input sample, signed |
| outValid | output | 1 | Output sample valid |
| outData | output | 35 | Filtered output, signed, full precision |

## Verification
The hardest case to create from the ports is a commit that lands in the middle of a stream. It has to coincide with a staging write to entry 0 on the same edge, while idle gaps sit between samples, so that outputs mixing the old and new sets can be told apart. The bench drives one long stream with a gap every fifth cycle, stages a highpass set while lowpass outputs are still emerging, and raises the commit together with a write of a distinct value. A bit-accurate model checks every output against the expected result, with the switch applied at the same sample index. An impulse read-out of the active bank, a sweep over all out-of-range addresses and a full-scale negative load cover the rest.

// File: rtl/fir_prog_pkg.sv
package fir_prog_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic shiftEn;     // accept a sample into the delay line
    logic loadShadow;  // copy staging bank into active bank
  } fir_strobe_t;

  function automatic int accWidth(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir_prog_ctrl.sv
module fir_prog_ctrl
  import fir_prog_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int CW   = 16,
  parameter int AW   = $clog2(TAPS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        coefData,
  input  logic [AW-1:0]        coefAddr,
  input  logic                 coefWe,
  input  logic                 coefDone,
  input  logic                 inValid,
  output fir_strobe_t          strobe,
  output logic [TAPS*CW-1:0]   coefFlat
);

  logic addrInRange;
  assign addrInRange = (int'(coefAddr) < TAPS);

  always_comb begin
    strobe.shiftEn    = inValid;
    strobe.loadShadow = coefDone;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    logic hit;
    assign hit = coefWe && addrInRange && (int'(coefAddr) == k);
    always_ff @(posedge clk) begin
      if (rst) begin
        coefFlat[k*CW +: CW] <= '0;
      end else if (hit) begin
        coefFlat[k*CW +: CW] <= coefData;
      end
    end
  end

endmodule

// File: rtl/fir_prog_datapath.sv
module fir_prog_datapath
  import fir_prog_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACC_W = DW + CW + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fir_strobe_t             strobe,
  input  logic [TAPS*CW-1:0]      coefFlat,
  input  logic signed [DW-1:0]    inData,
  output logic [TAPS*CW-1:0]      shadowFlat,
  output logic                    outValid,
  output logic signed [ACC_W-1:0] outData
);

  localparam int PW = DW + CW;

  logic signed [DW-1:0] taps [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] accSum;
  logic sampleFlag;

  // active bank
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowFlat <= '0;
    end else if (strobe.loadShadow) begin
      shadowFlat <= coefFlat;
    end
  end

  // delay line
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) taps[0] <= '0;
        else if (strobe.shiftEn) taps[0] <= inData;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) taps[k] <= '0;
        else if (strobe.shiftEn) taps[k] <= taps[k-1];
      end
    end
    assign prod[k] = taps[k] * $signed(shadowFlat[k*CW +: CW]);
  end

  always_comb begin
    accSum = '0;
    for (int k = 0; k < TAPS; k++) begin
      accSum = accSum + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleFlag <= 1'b0;
      outValid   <= 1'b0;
      outData    <= '0;
    end else begin
      sampleFlag <= strobe.shiftEn;
      outValid   <= sampleFlag;
      if (sampleFlag) outData <= accSum;
    end
  end

endmodule

// File: rtl/fir_prog_top.sv
module fir_prog_top
  import fir_prog_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int CW   = 16
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [CW-1:0]                                coefData,
  input  logic [$clog2(TAPS):0]                        coefAddr,
  input  logic                                         coefWe,
  input  logic                                         coefDone,
  input  logic                                         inValid,
  input  logic signed [DW-1:0]                         inData,
  output logic                                         outValid,
  output logic signed [DW+CW+$clog2(TAPS)-1:0]         outData
);

  localparam int AW    = $clog2(TAPS) + 1;
  localparam int ACC_W = DW + CW + $clog2(TAPS);

  fir_strobe_t            strobe;
  logic [TAPS*CW-1:0]     coefFlat;
  logic [TAPS*CW-1:0]     shadowFlat;

  fir_prog_ctrl #(.TAPS(TAPS), .CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .coefData(coefData), .coefAddr(coefAddr),
    .coefWe(coefWe), .coefDone(coefDone), .inValid(inValid),
    .strobe(strobe), .coefFlat(coefFlat)
  );

  fir_prog_datapath #(.TAPS(TAPS), .DW(DW), .CW(CW), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .coefFlat(coefFlat),
    .inData(inData), .shadowFlat(shadowFlat), .outValid(outValid),
    .outData(outData)
  );

endmodule

// File: rtl/fir_prog_checker.sv
module fir_prog_checker #(
  parameter int TAPS = 8,
  parameter int CW   = 16,
  parameter int AW   = 4,
  parameter int OW   = 35
) (
  input logic               clk,
  input logic               rst,
  input logic [CW-1:0]      coefData,
  input logic [AW-1:0]      coefAddr,
  input logic               coefWe,
  input logic               coefDone,
  input logic               inValid,
  input logic               outValid,
  input logic [OW-1:0]      outData,
  input logic [TAPS*CW-1:0] coefFlat,
  input logic [TAPS*CW-1:0] shadowFlat
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && outData == '0 && shadowFlat == '0 && coefFlat == '0));

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid && !rst, 2));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(coefDone && !rst) |-> shadowFlat == $past(coefFlat));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!coefDone && !rst) |-> $stable(shadowFlat));

  // R3
  addr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !(coefWe && int'(coefAddr) < TAPS)) |-> $stable(coefFlat));

  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && coefWe && int'(coefAddr) < TAPS) |->
      coefFlat[int'($past(coefAddr))*CW +: CW] == $past(coefData));

endmodule

bind fir_prog_top fir_prog_checker #(
  .TAPS(TAPS), .CW(CW), .AW($clog2(TAPS) + 1), .OW(DW + CW + $clog2(TAPS))
) u_chk (
  .clk(clk), .rst(rst), .coefData(coefData), .coefAddr(coefAddr),
  .coefWe(coefWe), .coefDone(coefDone), .inValid(inValid),
  .outValid(outValid), .outData(outData), .coefFlat(coefFlat),
  .shadowFlat(shadowFlat)
);

// File: tb/fir_prog_top_tb_top.sv
`timescale 1ns/1ps
module fir_prog_top_tb_top;

  localparam int TAPS = 8;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int AW   = 4;
  localparam int OW   = 35;

  logic clk = 1'b0;
  logic rst;
  logic [CW-1:0] coefData;
  logic [AW-1:0] coefAddr;
  logic coefWe, coefDone, inValid;
  logic signed [DW-1:0] inData;
  logic outValid;
  logic signed [OW-1:0] outData;

  always #2.5 clk = ~clk;

  fir_prog_top #(.TAPS(TAPS), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .coefData(coefData), .coefAddr(coefAddr),
    .coefWe(coefWe), .coefDone(coefDone), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  int checkCount = 0;
  int failCount  = 0;
  string curReq = "R1";

  longint mStage [TAPS];
  longint mActive[TAPS];
  longint mHist  [TAPS];
  logic   pendValid = 1'b0;
  longint pendExp = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check previous result after the edge, update model
  task automatic cycle(input logic v, input longint x, input logic we,
                       input int addr, input longint data, input logic done);
    @(negedge clk);
    inValid  = v;
    inData   = DW'(x);
    coefWe   = we;
    coefAddr = AW'(addr);
    coefData = CW'(data);
    coefDone = done;
    @(posedge clk);
    #1;
    check({curReq, "/R9 valid"}, longint'(outValid), longint'(pendValid));
    if (pendValid) check({curReq, " data"}, outData, pendExp);
    if (done) for (int k = 0; k < TAPS; k++) mActive[k] = mStage[k];
    if (we && addr < TAPS) mStage[addr] = data;
    pendValid = v;
    if (v) begin
      for (int k = TAPS-1; k > 0; k--) mHist[k] = mHist[k-1];
      mHist[0] = x;
      pendExp = 0;
      for (int k = 0; k < TAPS; k++) pendExp += mActive[k] * mHist[k];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0, 0, 0, 1'b0);
  endtask

  function automatic longint lowCoef(input int k);
    int t = (k < TAPS/2) ? k : TAPS-1-k;
    return 120 + 400*t*t;
  endfunction

  function automatic longint highCoef(input int k);
    return ((k % 2) == 0 ? 1 : -1) * (900 - 60*k);
  endfunction

  initial begin
    #1000000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin mStage[k] = 0; mActive[k] = 0; mHist[k] = 0; end
    rst = 1'b1; inValid = 0; inData = 0; coefWe = 0; coefAddr = 0; coefData = 0; coefDone = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: cleared outputs after reset
    check("R1 outValid", longint'(outValid), 0);
    check("R1 outData", outData, 0);
    curReq = "R1";
    cycle(1'b1, 1000, 1'b0, 0, 0, 1'b0);
    cycle(1'b1, -777, 1'b0, 0, 0, 1'b0);
    idle(2);

    // R5: staging writes without commit change nothing
    curReq = "R5";
    for (int k = 0; k < TAPS; k++) cycle(1'b1, 50*k + 3, 1'b1, k, lowCoef(k), 1'b0);
    idle(2);

    // R2: commit then impulse reads active bank back tap by tap
    curReq = "R2";
    cycle(1'b0, 0, 1'b0, 0, 0, 1'b1);
    for (int i = 0; i < TAPS; i++) cycle(1'b1, 0, 1'b0, 0, 0, 1'b0);
    cycle(1'b1, 1, 1'b0, 0, 0, 1'b0);
    for (int i = 0; i < TAPS; i++) cycle(1'b1, 0, 1'b0, 0, 0, 1'b0);
    idle(1);

    // R7/R8/R4: stream with gaps, stage highpass mid-stream, commit with simultaneous write
    curReq = "R8";
    for (int i = 0; i < 60; i++) begin
      logic v = (i % 5) != 4;
      longint x = ((i*i*37 + 11*i) % 4001) - 2000;
      logic we = 1'b0; int a = 0; longint d = 0; logic dn = 1'b0;
      if (i >= 10 && i < 10 + TAPS) begin we = 1'b1; a = i - 10; d = highCoef(i - 10); end
      if (i == 30) begin curReq = "R4"; dn = 1'b1; we = 1'b1; a = 0; d = 9999; end
      if (i == 31) curReq = "R7";
      cycle(v, x, we, a, d, dn);
    end
    idle(2);

    // R3: every out-of-range address ignored, then commit to expose staging bank
    curReq = "R3";
    for (int a = TAPS; a < (1 << AW); a++) cycle(1'b0, 0, 1'b1, a, -1234, 1'b0);
    cycle(1'b0, 0, 1'b0, 0, 0, 1'b1);
    cycle(1'b1, 1, 1'b0, 0, 0, 1'b0);
    for (int i = 0; i < TAPS; i++) cycle(1'b1, 0, 1'b0, 0, 0, 1'b0);
    idle(1);

    // R6: full-scale negative products at full precision
    curReq = "R6";
    for (int k = 0; k < TAPS; k++) cycle(1'b0, 0, 1'b1, k, -32768, 1'b0);
    cycle(1'b0, 0, 1'b0, 0, 0, 1'b1);
    for (int i = 0; i < TAPS + 2; i++) cycle(1'b1, -32768, 1'b0, 0, 0, 1'b0);
    idle(1);
    check("R6 full scale", outData, longint'(1) <<< 33);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule